// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures a set of interrupt request lines (eight by default) into a request vector that a downstream priority arbiter reads. Each line is sensed either on its rising edge or by its level. A per-line trigger-mode register selects the sensing. The block stores the level of every line from the previous clock, so it can detect a low-to-high transition.

When the arbiter services a line, it sends a single-cycle acknowledge with the line index. The acknowledge clears the request bit of an edge-sensed line. A level-sensed request ignores the acknowledge and keeps following its line. The trigger-mode register has a byte-wide write and read port. A per-instance writable mask forces selected lines to stay edge-sensed. The primary instance uses mask 0xF8 and the secondary uses 0xDE.

All inputs are plain single-cycle controls and there is no data stream. The acknowledge and the mode write are accepted in every cycle they are asserted, so there is no ready signal and no back-pressure. The caller must not hold them for more than the intended cycles.

Top module: `irq_req_latch`

## Requirements
- R1: Reset sets the request vector, the previous-level store and the trigger-mode register to zero. A line that is already high when reset is released is treated as a fresh rising edge.
- R2: Mode bit 0 selects edge sensing. The request bit for that line becomes 1 one clock after an edge at which the line is high and was low at the previous edge.
- R3: An edge-sensed line held high sets its request only once. After an acknowledge, the bit stays 0 while the line stays high.
- R4: A falling edge on an edge-sensed line leaves its request bit unchanged.
- R5: Mode bit 1 selects level sensing. The request bit then equals the line value sampled at the previous clock edge, so it sets while the line is high and clears when it goes low.
- R6: An acknowledge (ack_valid high for one cycle, ack_idx = line number 0..7) clears that line's request bit one clock later if the line is edge-sensed. All other request bits are unaffected.
- R7: An acknowledge to a level-sensed line has no effect on its request bit.
- R8: If a new rising edge and an acknowledge hit the same edge-sensed line in the same cycle, the request bit is set.
- R9: A mode write stores mode_wr_data AND WR_MASK, one clock after mode_wr_en. Bits outside the mask always read 0 and those lines stay edge-sensed. The default mask is 0xF8, and a secondary instance uses 0xDE.
- R10: mode_rd_data always shows the stored trigger-mode value, and a new mode value governs sensing from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt request lines |
| req_vec | output | NUM_LINES | Latched request vector to the arbiter |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_idx | input | IDX_W | Line index being acknowledged |
| mode_wr_en | input | 1 | Trigger-mode register write strobe |
| mode_wr_data | input | NUM_LINES | Trigger-mode write value (1 = level, 0 = edge) |
| mode_rd_data | output | NUM_LINES | Stored trigger-mode value |

## Verification
A stale previous-level bit shows one clock later at req_vec. It either misses a request or sets a second request while a line is held high after an acknowledge, so the acknowledge-then-hold scenario exposes it within two cycles. A wrong trigger-mode bit shows up as a request that survives an acknowledge, or as a level request that fails to drop. This is visible one cycle after the stimulus, and the masked bits can also be seen directly on mode_rd_data right after a write. The collision of an acknowledge with a new edge tests the order of set and clear in a single cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int DEF_LINES = 8;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
  parameter int N = 8,
  parameter logic [N-1:0] WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_en)
      mode_q <= wr_data & WR_MASK;
  end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign hit[g] = ack_valid && (ack_idx == IW'(g));
  end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_in,
  input  trig_e trig,
  input  logic  ack_hit,
  output logic  req_q,
  output logic  prev_q
);
  logic rise;
  assign rise = line_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= line_in;
      if (trig == TRIG_LEVEL)
        req_q <= line_in;
      else if (rise)
        req_q <= 1'b1;
      else if (ack_hit)
        req_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int NUM_LINES = DEF_LINES,
  parameter logic [NUM_LINES-1:0] WR_MASK = 8'hF8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] req_vec,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 mode_wr_en,
  input  logic [NUM_LINES-1:0] mode_wr_data,
  output logic [NUM_LINES-1:0] mode_rd_data
);
  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] ack_hit;
  logic [NUM_LINES-1:0] prev_vec;

  irq_trig_mode_reg #(.N(NUM_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (mode_q)
  );

  irq_ack_decode #(.N(NUM_LINES), .IW(IDX_W)) u_ack (
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .hit       (ack_hit)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (irq_in[g]),
      .trig    (trig_e'(mode_q[g])),
      .ack_hit (ack_hit[g]),
      .req_q   (req_vec[g]),
      .prev_q  (prev_vec[g])
    );
  end

  assign mode_rd_data = mode_q;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter logic [N-1:0] WR_MASK = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  irq_in,
  input logic [N-1:0]  req_vec,
  input logic          ack_valid,
  input logic [IW-1:0] ack_idx,
  input logic          mode_wr_en,
  input logic [N-1:0]  mode_wr_data,
  input logic [N-1:0]  mode_rd_data,
  input logic [N-1:0]  prev
);
  logic [N-1:0] ackm, edge_m, rise_m, hold_m;
  assign ackm   = ack_valid ? (N'(1) << ack_idx) : '0;
  assign edge_m = ~mode_rd_data;
  assign rise_m = edge_m & irq_in & ~prev;
  assign hold_m = edge_m & ~rise_m & ~ackm;

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & $past(rise_m)) == $past(rise_m))); // R2
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & $past(hold_m)) == ($past(req_vec) & $past(hold_m)))); // R4
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & $past(mode_rd_data)) == ($past(irq_in) & $past(mode_rd_data)))); // R5
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & $past(ackm & edge_m & ~rise_m)) == '0)); // R6
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> (mode_rd_data == ($past(mode_wr_data) & WR_MASK))); // R9
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_en |=> $stable(mode_rd_data)); // R10
endmodule

bind irq_req_latch irq_req_latch_chk #(.N(NUM_LINES), .IW(IDX_W), .WR_MASK(WR_MASK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_in       (irq_in),
  .req_vec      (req_vec),
  .ack_valid    (ack_valid),
  .ack_idx      (ack_idx),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .mode_rd_data (mode_rd_data),
  .prev         (prev_vec)
);

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic [7:0] req_vec;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic [7:0] mode_rd_data;
  logic       b_wr_en = 1'b0;
  logic [7:0] b_wr_data = '0;
  logic [7:0] b_req, b_mode;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_req_latch dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_vec(req_vec),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .mode_wr_en(mode_wr_en),
    .mode_wr_data(mode_wr_data), .mode_rd_data(mode_rd_data)
  );

  irq_req_latch #(.WR_MASK(8'hDE)) dut_b (
    .clk(clk), .rst_n(rst_n), .irq_in(8'h00), .req_vec(b_req),
    .ack_valid(1'b0), .ack_idx(3'd0), .mode_wr_en(b_wr_en),
    .mode_wr_data(b_wr_data), .mode_rd_data(b_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack(input logic [2:0] idx);
    ack_valid = 1'b1; ack_idx = idx;
    step();
    ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    irq_in = 8'h01;
    chk("R1 req in reset", req_vec, 8'h00);
    chk("R1 mode in reset", mode_rd_data, 8'h00);
    step(); rst_n = 1'b1;
    step();
    chk("R1 prev cleared, held line seen as edge", req_vec, 8'h01);
    irq_in = 8'h00; step();
    ack(3'd0);
    chk("R1 cleanup", req_vec, 8'h00);
  endtask

  task automatic t_edge();
    irq_in = 8'h12; step();
    chk("R2 rising edge sets", req_vec, 8'h12);
    irq_in = 8'h00; step();
    chk("R4 falling edge holds", req_vec, 8'h12);
    ack(3'd1);
    chk("R6 ack clears only line 1", req_vec, 8'h10);
    ack(3'd4);
    chk("R6 ack clears line 4", req_vec, 8'h00);
  endtask

  task automatic t_hold_high();
    irq_in = 8'h04; step();
    chk("R3 set", req_vec, 8'h04);
    ack(3'd2);
    chk("R3 ack while high", req_vec, 8'h00);
    step(); step();
    chk("R3 no re-set while high", req_vec, 8'h00);
    irq_in = 8'h00; step();
  endtask

  task automatic t_level();
    mode_wr_data = 8'h08; mode_wr_en = 1'b1; step(); mode_wr_en = 1'b0;
    chk("R10 readback", mode_rd_data, 8'h08);
    irq_in = 8'h08; step();
    chk("R5 level sets", req_vec, 8'h08);
    irq_in = 8'h00; step();
    chk("R5 level clears", req_vec, 8'h00);
    irq_in = 8'h08; step();
    ack(3'd3);
    chk("R7 ack on level line ignored", req_vec, 8'h08);
    irq_in = 8'h00; step();
    chk("R5 drop after ack", req_vec, 8'h00);
  endtask

  task automatic t_collide();
    irq_in = 8'h20; step();
    irq_in = 8'h00; step();
    chk("R4 hold after fall", req_vec, 8'h20);
    irq_in = 8'h20; ack(3'd5);
    chk("R8 edge beats ack", req_vec, 8'h20);
    ack(3'd5);
    chk("R8 later ack clears", req_vec, 8'h00);
    irq_in = 8'h00; step();
  endtask

  task automatic t_mask();
    mode_wr_data = 8'hFF; mode_wr_en = 1'b1; step(); mode_wr_en = 1'b0;
    chk("R9 primary mask", mode_rd_data, 8'hF8);
    irq_in = 8'h01; step();
    ack(3'd0);
    chk("R9 line 0 stays edge", req_vec, 8'h00);
    irq_in = 8'h00; step();
    mode_wr_data = 8'h07; mode_wr_en = 1'b1; step(); mode_wr_en = 1'b0;
    chk("R9 fixed bits read zero", mode_rd_data, 8'h00);
    b_wr_data = 8'hFF; b_wr_en = 1'b1; step(); b_wr_en = 1'b0;
    chk("R9 secondary mask", b_mode, 8'hDE);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    step();
    t_reset();
    t_edge();
    t_hold_high();
    t_level();
    t_collide();
    t_mask();
    done = 1'b1;
    finish_run();
  end
endmodule